// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor core. It completes one instruction on every rising clock edge: it fetches the instruction, decodes it, reads its operands, computes the result and writes it back within one clock period. The instruction set is a compact load/store subset. It covers four register-to-register operations (add, subtract, and, or), an OR with an immediate, a word load, a word store and a branch taken when two registers are equal.

The core drives an instruction address and receives the instruction word combinationally in the same cycle. The data side works the same way. The core drives an address and reads the data back combinationally. A store raises a write enable for one cycle, and the external memory captures the write data at the next rising edge. There is no branch delay slot and no load delay slot. The instruction after a taken branch is the target, and the instruction after a load already sees the loaded value. The reset is asynchronous and active low, and the system is expected to release it synchronously to the clock.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` equals RESET_PC (0 by default) and `dmem_we` is 0. After release, the first instruction is fetched from RESET_PC.
- R2: Fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and funct [5:0]. Opcode 0x00 with funct 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs−rt, rs AND rt or rs OR rt into rd. Sums and differences wrap modulo 2^32.
- R3: Opcode 0x0D writes rs OR the immediate [15:0], zero-extended, into rt. For example, 0x8000 gives 0x00008000.
- R4: Register 0 always reads as zero, and any write to it is discarded.
- R5: Opcode 0x23 writes the data-memory word at rs plus the sign-extended immediate into rt. The very next instruction sees the new value.
- R6: Opcode 0x2B raises `dmem_we` for that cycle only, with `dmem_addr` = rs plus the sign-extended immediate and `dmem_wdata` = rt. No other instruction raises `dmem_we`, and a store writes no register.
- R7: When no branch is taken, the fetch address advances by 4 on every cycle.
- R8: Opcode 0x04 compares rs with rt. When they are equal, the next fetch address is PC+4 plus the sign-extended immediate shifted left by 2. Both forward and backward targets work, and there is no delay slot. When they differ, the next fetch address is PC+4. A branch writes nothing.
- R9: Any other opcode, and opcode 0x00 with any other funct, writes neither a register nor memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | DATA_W | Fetch address (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | DATA_W | Data memory address for loads and stores |
| dmem_wdata | output | DATA_W | Store data |
| dmem_rdata | input | DATA_W | Load data at `dmem_addr`, combinational |
| dmem_we | output | 1 | Store enable, captured by memory at the rising edge |

## Verification
The bench builds the core with its default parameters: a 32-bit datapath, 32 registers and a reset address of zero. With these values, immediates cover their full range, including negative load and store offsets and a backward branch into a counted loop. Add and subtract results can wrap at 32 bits, and register 0 can be targeted both as a source and as a destination. Register contents are observed only by storing them into the bench's data memory. This makes a wrong write-back or an ignored write visible at the data port.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  // primary opcodes, bits [31:26]
  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  // function codes for register-register operations, bits [5:0]
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;       // write back to register file
    logic    dst_is_rd;    // destination field: rd (1) or rt (0)
    logic    b_is_imm;     // ALU second operand from immediate
    logic    imm_zext;     // zero-extend (1) or sign-extend (0)
    logic    mem_we;       // store
    logic    wb_from_mem;  // write-back source is load data
    logic    branch;       // branch-if-equal
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{reg_we: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0, imm_zext: 1'b0,
             mem_we: 1'b0, wb_from_mem: 1'b0, branch: 1'b0, alu_op: ALU_ADD};
    case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        case (funct)
          FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
          FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
          FN_AND: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_AND; end
          FN_OR:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_OR;  end
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OPC_ORI: begin
        ctrl.reg_we   = 1'b1;
        ctrl.b_is_imm = 1'b1;
        ctrl.imm_zext = 1'b1;
        ctrl.alu_op   = ALU_OR;
      end
      OPC_LW: begin
        ctrl.reg_we      = 1'b1;
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.alu_op      = ALU_ADD;
      end
      OPC_SW: begin
        ctrl.mem_we   = 1'b1;
        ctrl.b_is_imm = 1'b1;
        ctrl.alu_op   = ALU_ADD;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              eq
);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end

  // operand equality for the branch decision
  assign eq = (a == b);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 32,
  localparam int AW       = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata
);

  logic [REG_COUNT-1:0][DATA_W-1:0] bank;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign bank[i] = '0;
    end else begin : g_store
      logic              wen;
      logic [DATA_W-1:0] q;
      assign wen = we && (waddr == AW'(i));
      always_ff @(posedge clk) begin
        if (wen) q <= wdata;
      end
      assign bank[i] = q;
    end
  end

  assign rdata_a = bank[raddr_a];
  assign rdata_b = bank[raddr_b];

  assert_r0_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr_a == '0) |-> (rdata_a == '0));
  assert_r0_reads_zero_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr_b == '0) |-> (rdata_b == '0));

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              REG_COUNT = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] imem_addr,
  input  logic [31:0]       imem_rdata,
  output logic [DATA_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  input  logic [DATA_W-1:0] dmem_rdata,
  output logic              dmem_we
);

  localparam int REG_AW = $clog2(REG_COUNT);
  localparam int IMM_W  = 16;

  // instruction fields
  logic [5:0]        opcode;
  logic [5:0]        funct;
  logic [REG_AW-1:0] rs, rt, rd;
  logic [IMM_W-1:0]  imm;

  assign opcode = imem_rdata[31:26];
  assign rs     = imem_rdata[21 +: REG_AW];
  assign rt     = imem_rdata[16 +: REG_AW];
  assign rd     = imem_rdata[11 +: REG_AW];
  assign imm    = imem_rdata[IMM_W-1:0];
  assign funct  = imem_rdata[5:0];

  ctrl_t ctrl;

  sc_decoder u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  // immediate extension
  logic [DATA_W-1:0] ext_imm;
  assign ext_imm = ctrl.imm_zext ? {{(DATA_W-IMM_W){1'b0}}, imm}
                                 : {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

  // register file
  logic [DATA_W-1:0] rs_val, rt_val, wb_val;
  logic [REG_AW-1:0] dst;
  logic              rf_we;

  assign dst   = ctrl.dst_is_rd ? rd : rt;
  assign rf_we = ctrl.reg_we & rst_n;

  sc_regfile #(
    .DATA_W    (DATA_W),
    .REG_COUNT (REG_COUNT)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .raddr_a (rs),
    .raddr_b (rt),
    .rdata_a (rs_val),
    .rdata_b (rt_val),
    .we      (rf_we),
    .waddr   (dst),
    .wdata   (wb_val)
  );

  // execute
  logic [DATA_W-1:0] alu_b, alu_y;
  logic              alu_eq;

  assign alu_b = ctrl.b_is_imm ? ext_imm : rt_val;

  sc_alu #(.DATA_W(DATA_W)) u_alu (
    .op (ctrl.alu_op),
    .a  (rs_val),
    .b  (alu_b),
    .y  (alu_y),
    .eq (alu_eq)
  );

  assign wb_val     = ctrl.wb_from_mem ? dmem_rdata : alu_y;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we & rst_n;

  // program counter: next-state logic
  logic [DATA_W-1:0] pc_q, pc_d, pc_plus4, br_target;
  logic              take_branch;

  assign pc_plus4    = pc_q + DATA_W'(4);
  assign br_target   = pc_plus4 + {ext_imm[DATA_W-3:0], 2'b00};
  assign take_branch = ctrl.branch & alu_eq;

  always_comb begin
    pc_d = pc_plus4;
    if (take_branch) pc_d = br_target;
  end

  // program counter: register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  assign imem_addr = pc_q;

  // checks next to the logic they guard
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (imem_addr == RESET_PC && !dmem_we));

  assert_seq_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.branch && alu_eq) |=> (imem_addr == $past(imem_addr) + DATA_W'(4)));

  assert_branch_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.branch && alu_eq) |=>
      (imem_addr == $past(imem_addr + DATA_W'(4) + {ext_imm[DATA_W-3:0], 2'b00})));

  assert_store_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (imem_rdata[31:26] == OPC_SW));

  assert_rf_write_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (imem_rdata[31:26] == OPC_ORI || imem_rdata[31:26] == OPC_LW ||
               (imem_rdata[31:26] == OPC_RTYPE &&
                (imem_rdata[5:0] == FN_ADD || imem_rdata[5:0] == FN_SUB ||
                 imem_rdata[5:0] == FN_AND || imem_rdata[5:0] == FN_OR))));

  assert_ori_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_rdata[31:26] == OPC_ORI) |-> (alu_b[DATA_W-1:IMM_W] == '0));

endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sc_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata),
    .dmem_we    (dmem_we)
  );

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
  end

  // encoders
  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd_i, input int rs_i, input int rt_i);
    return {6'h00, 5'(rs_i), 5'(rt_i), 5'(rd_i), 5'h00, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt_i, input int rs_i, input logic [15:0] im);
    return {op, 5'(rs_i), 5'(rt_i), im};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic begin_prog();
    rst_n = 1'b0;
    for (int k = 0; k < 256; k++) begin
      imem[k] = 32'h0;
      dmem[k] = 32'h0;
    end
  endtask

  task automatic release_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_pc(input logic [31:0] target, input string req);
    int k;
    for (k = 0; k < 200; k++) begin
      if (imem_addr === target) break;
      @(negedge clk);
    end
    check(imem_addr === target, req, imem_addr, target);
  endtask

  // R1 / R7: reset state, store held off during reset, first fetch
  task automatic t_reset();
    begin_prog();
    imem[0] = enc_i(6'h2B, 0, 0, 16'h0000);
    repeat (2) @(negedge clk);
    chk_eq("R1 pc in reset", imem_addr, 32'h0);
    chk_eq("R1 no store in reset", {31'b0, dmem_we}, 32'h0);
    rst_n = 1'b1;
    #0.5;
    chk_eq("R6 store enable at pc0", {31'b0, dmem_we}, 32'h1);
    @(negedge clk);
    chk_eq("R7 pc advance", imem_addr, 32'h4);
    @(negedge clk);
    chk_eq("R7 pc advance again", imem_addr, 32'h8);
  endtask

  // R2: register-register operations, wrap
  task automatic t_alu();
    begin_prog();
    imem[0]  = enc_i(6'h0D, 1, 0, 16'h1234);
    imem[1]  = enc_i(6'h0D, 2, 0, 16'h00FF);
    imem[2]  = enc_r(6'h20, 3, 1, 2);
    imem[3]  = enc_r(6'h22, 4, 1, 2);
    imem[4]  = enc_r(6'h24, 5, 1, 2);
    imem[5]  = enc_r(6'h25, 6, 1, 2);
    imem[6]  = enc_i(6'h23, 7, 0, 16'h0080);
    imem[7]  = enc_i(6'h0D, 8, 0, 16'h0001);
    imem[8]  = enc_r(6'h20, 9, 7, 8);
    imem[9]  = enc_r(6'h22, 10, 0, 8);
    imem[10] = enc_i(6'h2B, 3, 0, 16'h0000);
    imem[11] = enc_i(6'h2B, 4, 0, 16'h0004);
    imem[12] = enc_i(6'h2B, 5, 0, 16'h0008);
    imem[13] = enc_i(6'h2B, 6, 0, 16'h000C);
    imem[14] = enc_i(6'h2B, 9, 0, 16'h0010);
    imem[15] = enc_i(6'h2B, 10, 0, 16'h0014);
    dmem[32] = 32'hFFFF_FFFF;
    dmem[4]  = 32'hDEAD_BEEF;
    release_reset();
    wait_pc(32'd64, "R7 reach end of alu program");
    chk_eq("R2 add", dmem[0], 32'h0000_1333);
    chk_eq("R2 sub", dmem[1], 32'h0000_1135);
    chk_eq("R2 and", dmem[2], 32'h0000_0034);
    chk_eq("R2 or",  dmem[3], 32'h0000_12FF);
    chk_eq("R2 add wraps", dmem[4], 32'h0000_0000);
    chk_eq("R2 sub wraps", dmem[5], 32'hFFFF_FFFF);
  endtask

  // R3 / R5 / R6: extension, negative offsets, load-use, store port
  task automatic t_mem();
    begin_prog();
    imem[0] = enc_i(6'h0D, 1, 0, 16'h8000);
    imem[1] = enc_i(6'h0D, 2, 0, 16'h0100);
    imem[2] = enc_i(6'h23, 3, 2, 16'hFFFC);
    imem[3] = enc_r(6'h20, 4, 3, 3);
    imem[4] = enc_i(6'h2B, 1, 2, 16'hFFF8);
    imem[5] = enc_i(6'h2B, 4, 0, 16'h0010);
    dmem[63] = 32'hCAFE_0001;
    release_reset();
    wait_pc(32'd8, "R7 reach load");
    chk_eq("R6 no store on load", {31'b0, dmem_we}, 32'h0);
    chk_eq("R5 load address sign-extended", dmem_addr, 32'h0000_00FC);
    @(negedge clk); @(negedge clk);
    chk_eq("R6 store enable", {31'b0, dmem_we}, 32'h1);
    chk_eq("R6 store address", dmem_addr, 32'h0000_00F8);
    chk_eq("R3 ori zero-extends", dmem_wdata, 32'h0000_8000);
    @(negedge clk); @(negedge clk);
    chk_eq("R3 stored ori value", dmem[62], 32'h0000_8000);
    chk_eq("R5 no load delay", dmem[4], 32'h95FC_0002);
  endtask

  // R4: register zero
  task automatic t_zero();
    begin_prog();
    imem[0] = enc_i(6'h0D, 0, 0, 16'h0055);
    imem[1] = enc_r(6'h20, 1, 0, 0);
    imem[2] = enc_i(6'h2B, 0, 0, 16'h0020);
    imem[3] = enc_i(6'h2B, 1, 0, 16'h0024);
    imem[4] = enc_i(6'h0D, 2, 0, 16'h0007);
    imem[5] = enc_r(6'h20, 0, 2, 2);
    imem[6] = enc_i(6'h2B, 0, 0, 16'h0028);
    dmem[8]  = 32'h1111;
    dmem[9]  = 32'h2222;
    dmem[10] = 32'h3333;
    release_reset();
    wait_pc(32'd28, "R7 reach end of zero program");
    chk_eq("R4 ori to r0 discarded", dmem[8], 32'h0);
    chk_eq("R4 r0 reads zero", dmem[9], 32'h0);
    chk_eq("R4 add to r0 discarded", dmem[10], 32'h0);
  endtask

  // R8: not taken, forward taken with skipped slots, backward loop
  task automatic t_branch();
    begin_prog();
    imem[0]  = enc_i(6'h0D, 1, 0, 16'h0005);
    imem[1]  = enc_i(6'h0D, 2, 0, 16'h0006);
    imem[2]  = enc_i(6'h0D, 5, 0, 16'h600D);
    imem[3]  = enc_i(6'h04, 2, 1, 16'h0004);
    imem[4]  = enc_i(6'h04, 0, 0, 16'h0002);
    imem[5]  = enc_i(6'h0D, 5, 0, 16'h0BAD);
    imem[6]  = enc_i(6'h0D, 5, 0, 16'h0BAD);
    imem[7]  = enc_i(6'h2B, 5, 0, 16'h0040);
    imem[8]  = enc_i(6'h0D, 1, 0, 16'h0003);
    imem[9]  = enc_i(6'h0D, 3, 0, 16'h0001);
    imem[10] = enc_i(6'h0D, 4, 0, 16'h0000);
    imem[11] = enc_r(6'h22, 1, 1, 3);
    imem[12] = enc_r(6'h20, 4, 4, 3);
    imem[13] = enc_i(6'h04, 0, 1, 16'h0001);
    imem[14] = enc_i(6'h04, 0, 0, 16'hFFFC);
    imem[15] = enc_i(6'h2B, 4, 0, 16'h0044);
    dmem[16] = 32'h7777;
    release_reset();
    wait_pc(32'd12, "R7 reach branch");
    chk_eq("R8 no store on branch", {31'b0, dmem_we}, 32'h0);
    @(negedge clk);
    chk_eq("R8 not taken goes to pc+4", imem_addr, 32'd16);
    @(negedge clk);
    chk_eq("R8 taken forward target", imem_addr, 32'd28);
    @(negedge clk);
    chk_eq("R8 no delay slot executed", dmem[16], 32'h0000_600D);
    wait_pc(32'd56, "R8 reach backward branch");
    @(negedge clk);
    chk_eq("R8 taken backward target", imem_addr, 32'd44);
    wait_pc(32'd64, "R8 loop exits");
    chk_eq("R8 loop count", dmem[17], 32'h3);
  endtask

  // R9: unrecognised encodings
  task automatic t_unknown();
    begin_prog();
    imem[0] = enc_i(6'h0D, 1, 0, 16'h0A0A);
    imem[1] = {6'h3F, 5'd0, 5'd1, 16'h1234};
    imem[2] = enc_r(6'h21, 1, 0, 0);
    imem[3] = {6'h2A, 5'd0, 5'd1, 16'h0010};
    imem[4] = enc_i(6'h2B, 1, 0, 16'h0030);
    dmem[4] = 32'h5555;
    release_reset();
    wait_pc(32'd4, "R7 reach unknown");
    chk_eq("R9 no store, bad opcode", {31'b0, dmem_we}, 32'h0);
    @(negedge clk);
    chk_eq("R9 pc+4 after bad opcode", imem_addr, 32'd8);
    chk_eq("R9 no store, bad funct", {31'b0, dmem_we}, 32'h0);
    @(negedge clk);
    chk_eq("R9 no store, store-like opcode", {31'b0, dmem_we}, 32'h0);
    @(negedge clk); @(negedge clk);
    chk_eq("R9 register untouched", dmem[12], 32'h0000_0A0A);
    chk_eq("R9 memory untouched", dmem[4], 32'h0000_5555);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_alu();
    t_mem();
    t_zero();
    t_branch();
    t_unknown();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

endmodule